// File: doc/BRIEF.md
# Shared-Written Line Classification Controller

This block keeps the coherence bookkeeping for the lines of a shared second-level cache. Instead of tracking which private caches hold a line, it records three bits per line: whether more than one core has touched it, whether it has ever been written, and whether the shared level currently holds the line's single exclusivity token. These three bits decide whether a line may live in private first-level caches. Lines that are private to one core, or that are shared but only read, are cacheable. Lines that are both shared and written are banished to the shared level.

Cores send one request per cycle: a read, a write-through, or an eviction notice. Each request carries the requester's ID and a flag that says whether the requester holds the token. The shared cache's own replacement logic can also send a drop request, which removes a line from the table.

The controller updates the line's bits. One cycle later it replies with a cacheable flag and a token-grant flag. When a line first becomes both shared and written, it sends a single invalidate broadcast for that line to all private caches. A directly indexed register array holds the line states and stands in for the cache.

Top module: `swcoh_ctrl`

## Requirements
- R1: After reset every line is absent, and `rsp_valid` and `inval_strobe` are low. A read of any line, including the highest index, is treated as a miss.
- R2: A read of an absent line fills it and hands the token to the requester. The response has cacheable=1 and grant=1. A grant is never given without cacheable.
- R3: A write to an absent line fills it as private-written, with cacheable=1 and grant=1. A write or read by the token holder (owns=1) leaves the line private: cacheable=1, grant=0, no broadcast.
- R4: An eviction notice from the token holder returns the token to the shared level. While the shared bit is clear, the next read or write from any core receives the token (grant=1, cacheable=1).
- R5: An access by a core that does not hold the token, while the shared level also lacks it, sets the shared bit. A read of an unwritten line then gets cacheable=1 and grant=0. Further readers change nothing.
- R6: When a line first has both shared and written set, the response has cacheable=0. `inval_strobe` is high for exactly that one response cycle, with `inval_line` equal to the request's line.
- R7: Every later read or write of a shared-written line gets cacheable=0 and grant=0 and raises no further broadcast.
- R8: An eviction notice from a core that does not hold the token changes nothing. Eviction responses always carry cacheable=0 and grant=0.
- R9: The shared and written bits are sticky. After the token returns home, an access to a line whose shared bit is set receives no grant.
- R10: A drop request clears all three bits and makes the line absent, so the next access is a fresh miss.
- R11: The request kind is encoded as 0 read, 1 write, 2 eviction notice, 3 drop. One request is accepted per cycle. Its response appears with `rsp_valid` high on the next cycle, with `rsp_core` echoing the requester. A cycle without a request yields `rsp_valid` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 eviction notice, 3 drop |
| req_core | input | CORE_W | Requesting core ID |
| req_line | input | LINE_W | Line index |
| req_owns | input | 1 | Requester currently holds the line's token |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_core | output | CORE_W | Core the response is for |
| rsp_cacheable | output | 1 | Requester may keep the line in its private cache |
| rsp_grant | output | 1 | Requester now holds the token |
| inval_strobe | output | 1 | One-cycle invalidate broadcast to all private caches |
| inval_line | output | LINE_W | Line to invalidate |

## Verification
The checker assumes the cores report token ownership honestly. `req_owns` is high only when that core was last granted the token and has not since given it back, and it is never high while the shared level holds the token. A property that the owner is never granted the token rests on this assumption.

The directed stimulus keeps this rule. Each scenario tracks which core it gave the token to, and sets owns only for that core until it sends an eviction notice. Eviction notices from non-owners are always sent with owns low, so the ignored-eviction case stays within the same rule.

// File: rtl/swcoh_pkg.sv
package swcoh_pkg;

    // Request encodings seen on req_kind
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_DROP  = 2'd3
    } op_e;

    // Per-line bookkeeping held at the shared level
    typedef struct packed {
        logic present;   // line is allocated in the table
        logic shared;    // touched by more than one core (sticky)
        logic written;   // written at least once (sticky)
        logic home_tok;  // exclusivity token sits at the shared level
    } line_st_t;

    // Outcome of one request
    typedef struct packed {
        logic cacheable;
        logic grant;
        logic inval;
    } verdict_t;

endpackage

// File: rtl/swcoh_next.sv
module swcoh_next
    import swcoh_pkg::*;
(
    input  op_e      op,
    input  logic     owns,
    input  line_st_t cur,
    output line_st_t nxt,
    output verdict_t vd
);

    logic foreign;     // neither the requester nor the shared level has the token
    logic shared_n;
    logic tok_leaves;  // token moves from the shared level to the requester
    logic was_sw;

    always_comb begin
        foreign    = !cur.home_tok && !owns;
        shared_n   = cur.shared || foreign;
        tok_leaves = !shared_n && cur.home_tok;
        was_sw     = cur.shared && cur.written;
        nxt        = cur;
        vd         = '0;
        unique case (op)
            OP_READ: begin
                if (!cur.present) begin
                    nxt = '{present: 1'b1, shared: 1'b0, written: 1'b0, home_tok: 1'b0};
                    vd  = '{cacheable: 1'b1, grant: 1'b1, inval: 1'b0};
                end else begin
                    nxt.shared   = shared_n;
                    nxt.home_tok = cur.home_tok && !tok_leaves;
                    vd.grant     = tok_leaves;
                    vd.cacheable = !(shared_n && cur.written);
                    vd.inval     = shared_n && cur.written && !was_sw;
                end
            end
            OP_WRITE: begin
                if (!cur.present) begin
                    nxt = '{present: 1'b1, shared: 1'b0, written: 1'b1, home_tok: 1'b0};
                    vd  = '{cacheable: 1'b1, grant: 1'b1, inval: 1'b0};
                end else begin
                    nxt.shared   = shared_n;
                    nxt.written  = 1'b1;
                    nxt.home_tok = cur.home_tok && !tok_leaves;
                    vd.grant     = tok_leaves;
                    vd.cacheable = !shared_n;
                    vd.inval     = shared_n && !was_sw;
                end
            end
            OP_EVICT: begin
                if (cur.present && !cur.home_tok && owns) begin
                    nxt.home_tok = 1'b1;
                end
            end
            OP_DROP: begin
                nxt = '0;
            end
            default: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/swcoh_store.sv
module swcoh_store
    import swcoh_pkg::*;
#(
    parameter  int NUM_LINES = 16,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_idx,
    input  line_st_t          wr_val,
    input  logic [LINE_W-1:0] rd_idx,
    output line_st_t          rd_val
);

    line_st_t table_d [NUM_LINES];
    line_st_t table_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_comb begin
            table_d[g] = table_q[g];
            if (wr_en && (wr_idx == LINE_W'(g))) begin
                table_d[g] = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                table_q[g] <= '0;
            end else begin
                table_q[g] <= table_d[g];
            end
        end
    end

    assign rd_val = table_q[rd_idx];

endmodule

// File: rtl/swcoh_ctrl.sv
module swcoh_ctrl
    import swcoh_pkg::*;
#(
    parameter  int NUM_CORES = 4,
    parameter  int NUM_LINES = 16,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [CORE_W-1:0] req_core,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_owns,
    output logic              rsp_valid,
    output logic [CORE_W-1:0] rsp_core,
    output logic              rsp_cacheable,
    output logic              rsp_grant,
    output logic              inval_strobe,
    output logic [LINE_W-1:0] inval_line
);

    typedef struct packed {
        logic              valid;
        logic [CORE_W-1:0] core;
        logic              cacheable;
        logic              grant;
        logic              inval;
        logic [LINE_W-1:0] line;
    } rsp_t;

    op_e      op;
    line_st_t cur_st;
    line_st_t nxt_st;
    verdict_t vd;
    rsp_t     rsp_d;
    rsp_t     rsp_q;

    assign op = op_e'(req_kind);

    swcoh_store #(.NUM_LINES(NUM_LINES)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (req_valid),
        .wr_idx (req_line),
        .wr_val (nxt_st),
        .rd_idx (req_line),
        .rd_val (cur_st)
    );

    swcoh_next next_i (
        .op   (op),
        .owns (req_owns),
        .cur  (cur_st),
        .nxt  (nxt_st),
        .vd   (vd)
    );

    always_comb begin
        rsp_d           = '0;
        rsp_d.line      = rsp_q.line;
        if (req_valid) begin
            rsp_d.valid     = 1'b1;
            rsp_d.core      = req_core;
            rsp_d.cacheable = vd.cacheable;
            rsp_d.grant     = vd.grant;
            rsp_d.inval     = vd.inval;
            rsp_d.line      = req_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_core      = rsp_q.core;
    assign rsp_cacheable = rsp_q.cacheable;
    assign rsp_grant     = rsp_q.grant;
    assign inval_strobe  = rsp_q.inval;
    assign inval_line    = rsp_q.line;

endmodule

// File: rtl/swcoh_ctrl_chk.sv
module swcoh_ctrl_chk #(
    parameter int CORE_W = 2,
    parameter int LINE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [CORE_W-1:0] req_core,
    input logic [LINE_W-1:0] req_line,
    input logic              req_owns,
    input logic              rsp_valid,
    input logic [CORE_W-1:0] rsp_core,
    input logic              rsp_cacheable,
    input logic              rsp_grant,
    input logic              inval_strobe,
    input logic [LINE_W-1:0] inval_line
);

    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_core_echo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_core == $past(req_core)));

    assert_grant_cacheable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_cacheable);

    assert_inval_uncacheable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inval_strobe |-> (rsp_valid && !rsp_cacheable && !rsp_grant));

    assert_inval_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inval_strobe |-> (inval_line == $past(req_line)));

    assert_evict_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> (!rsp_cacheable && !rsp_grant && !inval_strobe));

    assert_owner_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_owns) |=> !rsp_grant);

endmodule

bind swcoh_ctrl swcoh_ctrl_chk #(.CORE_W(CORE_W), .LINE_W(LINE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_core      (req_core),
    .req_line      (req_line),
    .req_owns      (req_owns),
    .rsp_valid     (rsp_valid),
    .rsp_core      (rsp_core),
    .rsp_cacheable (rsp_cacheable),
    .rsp_grant     (rsp_grant),
    .inval_strobe  (inval_strobe),
    .inval_line    (inval_line)
);

// File: tb/swcoh_ctrl_tb_top.sv
module swcoh_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCORES     = 4;
    localparam int NLINES     = 16;
    localparam int CW         = 2;
    localparam int LW         = 4;
    localparam int WATCHDOG   = 5000;

    localparam logic [1:0] K_RD = 2'd0;
    localparam logic [1:0] K_WR = 2'd1;
    localparam logic [1:0] K_EV = 2'd2;
    localparam logic [1:0] K_DR = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [CW-1:0] req_core = '0;
    logic [LW-1:0] req_line = '0;
    logic          req_owns = 1'b0;
    logic          rsp_valid;
    logic [CW-1:0] rsp_core;
    logic          rsp_cacheable;
    logic          rsp_grant;
    logic          inval_strobe;
    logic [LW-1:0] inval_line;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swcoh_ctrl #(.NUM_CORES(NCORES), .NUM_LINES(NLINES)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_core      (req_core),
        .req_line      (req_line),
        .req_owns      (req_owns),
        .rsp_valid     (rsp_valid),
        .rsp_core      (rsp_core),
        .rsp_cacheable (rsp_cacheable),
        .rsp_grant     (rsp_grant),
        .inval_strobe  (inval_strobe),
        .inval_line    (inval_line)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drives one request, samples its response at the next falling edge.
    task automatic issue(input logic [1:0] k, input int c, input int l, input logic o,
                         input logic e_c, input logic e_g, input logic e_i, input string tag);
        req_valid = 1'b1;
        req_kind  = k;
        req_core  = CW'(c);
        req_line  = LW'(l);
        req_owns  = o;
        @(negedge clk);
        req_valid = 1'b0;
        req_owns  = 1'b0;
        chk({tag, " valid"},     int'(rsp_valid),     1);
        chk({tag, " core"},      int'(rsp_core),      c);
        chk({tag, " cacheable"}, int'(rsp_cacheable), int'(e_c));
        chk({tag, " grant"},     int'(rsp_grant),     int'(e_g));
        chk({tag, " inval"},     int'(inval_strobe),  int'(e_i));
        if (e_i) chk({tag, " inval_line"}, int'(inval_line), l);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        chk({tag, " idle valid"}, int'(rsp_valid),    0);
        chk({tag, " idle inval"}, int'(inval_strobe), 0);
    endtask

    task automatic t_reset();
        chk("R1 reset valid", int'(rsp_valid),    0);
        chk("R1 reset inval", int'(inval_strobe), 0);
        issue(K_RD, 3, NLINES - 1, 1'b0, 1, 1, 0, "R1 top line miss");
    endtask

    task automatic t_first_read();
        issue(K_RD, 0, 1, 1'b0, 1, 1, 0, "R2 read miss");
        issue(K_RD, 0, 1, 1'b1, 1, 0, 0, "R3 owner reread");
    endtask

    task automatic t_owner_write();
        issue(K_WR, 0, 1, 1'b1, 1, 0, 0, "R3 owner write");
        issue(K_WR, 1, 2, 1'b0, 1, 1, 0, "R3 write miss");
        issue(K_WR, 1, 2, 1'b1, 1, 0, 0, "R3 owner rewrite");
    endtask

    task automatic t_evict_return();
        issue(K_EV, 0, 1, 1'b1, 0, 0, 0, "R4 owner evict");
        issue(K_RD, 2, 1, 1'b0, 1, 1, 0, "R4 reread after return");
        issue(K_EV, 2, 1, 1'b1, 0, 0, 0, "R4 evict again");
        issue(K_WR, 3, 1, 1'b0, 1, 1, 0, "R4 write after return");
    endtask

    task automatic t_shared_read();
        issue(K_RD, 0, 3, 1'b0, 1, 1, 0, "R5 first reader");
        issue(K_RD, 1, 3, 1'b0, 1, 0, 0, "R5 second reader");
        issue(K_RD, 2, 3, 1'b0, 1, 0, 0, "R5 third reader");
    endtask

    task automatic t_shared_write();
        issue(K_WR, 1, 3, 1'b0, 0, 0, 1, "R6 foreign write");
        idle("R6 strobe one cycle");
        issue(K_RD, 0, 3, 1'b1, 0, 0, 0, "R7 read shared-written");
        issue(K_WR, 2, 3, 1'b0, 0, 0, 0, "R7 write shared-written");
        issue(K_RD, 0, 4, 1'b0, 1, 1, 0, "R6 line4 fill");
        issue(K_RD, 1, 4, 1'b0, 1, 0, 0, "R6 line4 sharer");
        issue(K_WR, 0, 4, 1'b1, 0, 0, 1, "R6 owner write shared");
        issue(K_RD, 3, 2, 1'b0, 0, 0, 1, "R6 foreign read written");
    endtask

    task automatic t_ignored_evict();
        issue(K_RD, 0, 5, 1'b0, 1, 1, 0, "R8 fill");
        issue(K_EV, 1, 5, 1'b0, 0, 0, 0, "R8 non-owner evict");
        issue(K_RD, 2, 5, 1'b0, 1, 0, 0, "R8 token untouched");
    endtask

    task automatic t_sticky();
        issue(K_EV, 0, 5, 1'b1, 0, 0, 0, "R9 owner evict shared");
        issue(K_RD, 3, 5, 1'b0, 1, 0, 0, "R9 shared stays set");
        issue(K_WR, 3, 5, 1'b0, 0, 0, 1, "R9 shared then written");
    endtask

    task automatic t_drop();
        issue(K_DR, 0, 3, 1'b0, 0, 0, 0, "R10 drop");
        issue(K_RD, 1, 3, 1'b0, 1, 1, 0, "R10 fresh miss");
        issue(K_WR, 1, 3, 1'b1, 1, 0, 0, "R10 bits cleared");
    endtask

    task automatic t_timing();
        idle("R11 no request");
        issue(K_RD, 2, 7, 1'b0, 1, 1, 0, "R11 back to back a");
        issue(K_RD, 3, 8, 1'b0, 1, 1, 0, "R11 back to back b");
        idle("R11 after burst");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_read();
        t_owner_write();
        t_evict_return();
        t_shared_read();
        t_shared_write();
        t_ignored_evict();
        t_sticky();
        t_drop();
        t_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule